// File: doc/BRIEF.md
# Bit-Parallel Stuck-At Fault Simulator

This block runs a fixed six-input gate network of AND, OR and inverter gates on eight-bit lane words, so one pass over the gates evaluates the healthy circuit and seven faulty copies together. Lane 7 always holds the healthy circuit. Lanes 6 to 0 each take the single stuck-at fault held in fault slot 6 to 0. Faults are forced with per-lane AND and OR masks. A stuck-at-0 clears the lane's bit and a stuck-at-1 sets it, either where a gate reads an input pin or where a net is driven.

Every net carries a three-valued signal made from a value word and an unknown word. When the unknown bit is set the value bit reads 0. Each applied vector is spread across all lanes. The two outputs of the faulty lanes are compared with lane 7, and hard detections gather into a sticky mask. The block also reports the detected count, the simulated count and the vector at which each fault was first caught.

Net numbering: nets 0 to 5 are the primary inputs p0..p5. Nets 6 to 13 are the gates: n6=p0&p1, n7=p2&p3, n8=n6|n7, n9=!n8, n10=p4|p5, n11=n9&n10 (output 0), n12=!p4, n13=n7|n12 (output 1). For gate inputs, the first operand listed is pin A and the second is pin B.

Top module: `sa_lane_sim`

## Requirements
- R1: `good_v`/`good_x` report the healthy outputs (bit 0 = n11, bit 1 = n13) of the last applied vector, with po0 = !((p0&p1)|(p2&p3)) & (p4|p5) and po1 = (p2&p3) | !p4.
- R2: An input bit with `vec_unk`=1 is unknown (X) in every lane. Otherwise it is `vec_val` in every lane.
- R3: Unknowns propagate by three-valued rules: AND with a known 0 gives 0, OR with a known 1 gives 1, NOT of X gives X, and other X cases give X.
- R4: A write with `cfg_we`=1 stores the enable, net id (0..13), pin code and stuck value into slot `cfg_slot`, which drives lane `cfg_slot`. It takes effect from the next cycle. Pin code 0 is the net itself, 1 is gate pin A and 2 is gate pin B. Pin code 3, or a gate-pin code on an input net, has no effect. Writes to slot 7 are ignored.
- R5: A fault on a net (pin code 0) is seen by every gate that reads the net. A fault on a gate pin changes only that gate's view of the input.
- R6: A lane is detected on a vector only when, at some output, both the healthy and the faulty value are known and they differ.
- R7: `det_mask` bits stay set until `clear_faults`. A clear empties the mask, `first_vec` and `vec_count`, and takes priority: a vector offered in the same cycle is dropped and gives no `done`.
- R8: `done` is high in exactly the cycle after an accepted vector. In that cycle `new_det` shows the lanes first detected by that vector. Otherwise `new_det` is 0.
- R9: On a lane's first detection, `first_vec[8*l +: 8]` records the number of vectors accepted since the last clear, before that vector.
- R10: `sim_count` is the number of enabled slots, and `det_count` is the number of enabled slots whose detect bit is set.
- R11: A disabled slot leaves its lane identical to lane 7, and that lane is never detected.
- R12: After reset, `done`, `new_det`, `det_mask`, `vec_count`, `sim_count` and `det_count` are 0.
- R13: `vec_count` counts accepted vectors and holds at 255 once there.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| cfg_we | input | 1 | Fault slot write strobe |
| cfg_slot | input | 3 | Slot (lane) to write |
| cfg_en | input | 1 | Slot enable |
| cfg_net | input | 4 | Faulted net id |
| cfg_pin | input | 2 | 0 net, 1 pin A, 2 pin B |
| cfg_sv | input | 1 | Stuck value |
| clear_faults | input | 1 | Clear detections and vector count |
| vec_valid | input | 1 | Apply a vector this cycle |
| vec_val | input | 6 | Input values p5..p0 |
| vec_unk | input | 6 | Input unknown flags |
| done | output | 1 | Result of a vector is ready |
| good_v | output | 2 | Healthy output values |
| good_x | output | 2 | Healthy output unknown flags |
| new_det | output | 7 | Lanes first detected by last vector |
| det_mask | output | 7 | Sticky detected lanes |
| det_count | output | 3 | Detected enabled faults |
| sim_count | output | 3 | Enabled faults |
| vec_count | output | 8 | Vectors since clear |
| first_vec | output | 56 | First detecting vector per lane |

## Verification
A vector offered on one clock edge produces `done`, `new_det`, the updated mask, `first_vec`, `vec_count` and the healthy outputs right after the next edge. `det_count` follows the mask in that same cycle. A slot write changes `sim_count` one edge after the write. The bench drives on the falling edge and samples at the following falling edge, so every result is read one edge after its cause. Its expectations come from a per-lane scalar three-valued model of the network, with the fault hooked in at the net or pin that the slot names.

// File: rtl/fsim_pkg.sv
package fsim_pkg;
  localparam int NPI   = 6;
  localparam int NGATE = 8;
  localparam int NNET  = NPI + NGATE;
  localparam int NETW  = $clog2(NNET);
  localparam int NPO   = 2;
  localparam int PIN_W = 2;

  localparam logic [PIN_W-1:0] PIN_OUT = 2'd0;
  localparam logic [PIN_W-1:0] PIN_A   = 2'd1;
  localparam logic [PIN_W-1:0] PIN_B   = 2'd2;

  typedef enum logic [1:0] {OP_AND = 2'd0, OP_OR = 2'd1, OP_NOT = 2'd2} gate_op_e;

  typedef struct packed {
    gate_op_e        op;
    logic [NETW-1:0] src_a;
    logic [NETW-1:0] src_b;
  } gate_t;

  // Fixed network, gates listed in dependency order; gate g drives net NPI+g.
  function automatic gate_t gate_def(input int g);
    case (g)
      0:       return '{op: OP_AND, src_a: 4'd0,  src_b: 4'd1};
      1:       return '{op: OP_AND, src_a: 4'd2,  src_b: 4'd3};
      2:       return '{op: OP_OR,  src_a: 4'd6,  src_b: 4'd7};
      3:       return '{op: OP_NOT, src_a: 4'd8,  src_b: 4'd8};
      4:       return '{op: OP_OR,  src_a: 4'd4,  src_b: 4'd5};
      5:       return '{op: OP_AND, src_a: 4'd9,  src_b: 4'd10};
      6:       return '{op: OP_NOT, src_a: 4'd4,  src_b: 4'd4};
      default: return '{op: OP_OR,  src_a: 4'd7,  src_b: 4'd12};
    endcase
  endfunction

  function automatic int po_net(input int k);
    return (k == 0) ? 11 : 13;
  endfunction
endpackage

// File: rtl/fsim_fault_table.sv
module fsim_fault_table import fsim_pkg::*; #(
  parameter int LANES = 8,
  localparam int NSLOT  = LANES - 1,
  localparam int SLOT_W = $clog2(NSLOT)
) (
  input  logic                             clk,
  input  logic                             rst_n,
  input  logic                             cfg_we,
  input  logic [SLOT_W-1:0]                cfg_slot,
  input  logic                             cfg_en,
  input  logic [NETW-1:0]                  cfg_net,
  input  logic [PIN_W-1:0]                 cfg_pin,
  input  logic                             cfg_sv,
  output logic [NSLOT-1:0][NETW-1:0]       f_net,
  output logic [NSLOT-1:0][PIN_W-1:0]      f_pin,
  output logic [NSLOT-1:0]                 f_sv,
  output logic [NSLOT-1:0]                 f_en
);
  logic [NSLOT-1:0][NETW-1:0]  net_d;
  logic [NSLOT-1:0][PIN_W-1:0] pin_d;
  logic [NSLOT-1:0]            sv_d, en_d;
  logic                        wr_ok;

  assign wr_ok = cfg_we && (32'(cfg_slot) < NSLOT);

  always_comb begin
    net_d = f_net;
    pin_d = f_pin;
    sv_d  = f_sv;
    en_d  = f_en;
    if (wr_ok) begin
      net_d[cfg_slot] = cfg_net;
      pin_d[cfg_slot] = cfg_pin;
      sv_d[cfg_slot]  = cfg_sv;
      en_d[cfg_slot]  = cfg_en;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      f_net <= '0;
      f_pin <= '0;
      f_sv  <= '0;
      f_en  <= '0;
    end else if (wr_ok) begin
      f_net <= net_d;
      f_pin <= pin_d;
      f_sv  <= sv_d;
      f_en  <= en_d;
    end
  end

  // R4
  cfg_land_chk: assert property (@(posedge clk) disable iff (!rst_n)
    wr_ok |=> (f_en[$past(cfg_slot)] == $past(cfg_en)) && (f_net[$past(cfg_slot)] == $past(cfg_net)));
endmodule

// File: rtl/fsim_eval.sv
module fsim_eval import fsim_pkg::*; #(
  parameter int LANES = 8,
  localparam int NSLOT = LANES - 1
) (
  input  logic [NPI-1:0]                   pi_val,
  input  logic [NPI-1:0]                   pi_unk,
  input  logic [NSLOT-1:0][NETW-1:0]       f_net,
  input  logic [NSLOT-1:0][PIN_W-1:0]      f_pin,
  input  logic [NSLOT-1:0]                 f_sv,
  input  logic [NSLOT-1:0]                 f_en,
  output logic [NPO-1:0][LANES-1:0]        po_v,
  output logic [NPO-1:0][LANES-1:0]        po_x
);
  logic [NNET-1:0][LANES-1:0] nv, nx;
  logic [2*LANES-1:0]         m;
  logic [LANES-1:0]           av, ax, bv, bx, rv, rx;
  gate_t                      gd;

  // Upper half: AND mask (stuck-at-0), lower half: OR mask (stuck-at-1).
  function automatic logic [2*LANES-1:0] site_mask(input int n, input logic [PIN_W-1:0] p);
    logic [LANES-1:0] am;
    logic [LANES-1:0] om;
    am = '1;
    om = '0;
    for (int l = 0; l < NSLOT; l++) begin
      if (f_en[l] && (f_net[l] == NETW'(n)) && (f_pin[l] == p)) begin
        if (f_sv[l]) om[l] = 1'b1;
        else         am[l] = 1'b0;
      end
    end
    return {am, om};
  endfunction

  always_comb begin
    nv = '0;
    nx = '0;
    m  = '0;
    av = '0; ax = '0; bv = '0; bx = '0; rv = '0; rx = '0;
    gd = '{op: OP_AND, src_a: '0, src_b: '0};
    for (int i = 0; i < NPI; i++) begin
      m     = site_mask(i, PIN_OUT);
      nv[i] = ({LANES{pi_val[i] & ~pi_unk[i]}} & m[2*LANES-1:LANES]) | m[LANES-1:0];
      nx[i] = {LANES{pi_unk[i]}} & m[2*LANES-1:LANES] & ~m[LANES-1:0];
    end
    for (int g = 0; g < NGATE; g++) begin
      gd = gate_def(g);
      m  = site_mask(NPI + g, PIN_A);
      av = (nv[gd.src_a] & m[2*LANES-1:LANES]) | m[LANES-1:0];
      ax = nx[gd.src_a] & m[2*LANES-1:LANES] & ~m[LANES-1:0];
      m  = site_mask(NPI + g, PIN_B);
      bv = (nv[gd.src_b] & m[2*LANES-1:LANES]) | m[LANES-1:0];
      bx = nx[gd.src_b] & m[2*LANES-1:LANES] & ~m[LANES-1:0];
      case (gd.op)
        OP_AND: begin
          rv = av & bv;
          rx = (ax | bx) & (av | ax) & (bv | bx);
        end
        OP_OR: begin
          rv = av | bv;
          rx = (ax | bx) & ~av & ~bv;
        end
        default: begin
          rv = ~av & ~ax;
          rx = ax;
        end
      endcase
      m          = site_mask(NPI + g, PIN_OUT);
      nv[NPI+g]  = (rv & m[2*LANES-1:LANES]) | m[LANES-1:0];
      nx[NPI+g]  = rx & m[2*LANES-1:LANES] & ~m[LANES-1:0];
    end
  end

  for (genvar k = 0; k < NPO; k++) begin : g_po
    assign po_v[k] = nv[po_net(k)];
    assign po_x[k] = nx[po_net(k)];
  end
endmodule

// File: rtl/fsim_detect.sv
module fsim_detect import fsim_pkg::*; #(
  parameter int LANES  = 8,
  parameter int VIDX_W = 8,
  localparam int NSLOT = LANES - 1,
  localparam int CNT_W = $clog2(LANES)
) (
  input  logic                        clk,
  input  logic                        rst_n,
  input  logic                        clear_faults,
  input  logic                        vec_valid,
  input  logic [NPO-1:0][LANES-1:0]   po_v,
  input  logic [NPO-1:0][LANES-1:0]   po_x,
  input  logic [NSLOT-1:0]            f_en,
  output logic                        done,
  output logic [NPO-1:0]              good_v,
  output logic [NPO-1:0]              good_x,
  output logic [NSLOT-1:0]            new_det,
  output logic [NSLOT-1:0]            det_mask,
  output logic [CNT_W-1:0]            det_count,
  output logic [CNT_W-1:0]            sim_count,
  output logic [VIDX_W-1:0]           vec_count,
  output logic [NSLOT*VIDX_W-1:0]     first_vec
);
  logic [NSLOT-1:0]        hit, fresh;
  logic                    take;
  logic                    done_d;
  logic [NPO-1:0]          gv_d, gx_d;
  logic [NSLOT-1:0]        new_d, det_d;
  logic [VIDX_W-1:0]       vcnt_d;
  logic [NSLOT*VIDX_W-1:0] first_d;

  function automatic logic [CNT_W-1:0] pop(input logic [NSLOT-1:0] w);
    logic [CNT_W-1:0] c;
    c = '0;
    for (int i = 0; i < NSLOT; i++) c = c + CNT_W'(w[i]);
    return c;
  endfunction

  always_comb begin
    hit = '0;
    for (int l = 0; l < NSLOT; l++) begin
      for (int k = 0; k < NPO; k++) begin
        if (f_en[l] && !po_x[k][LANES-1] && !po_x[k][l] && (po_v[k][l] != po_v[k][LANES-1]))
          hit[l] = 1'b1;
      end
    end
  end

  assign fresh = hit & ~det_mask;
  assign take  = vec_valid && !clear_faults;

  always_comb begin
    done_d  = 1'b0;
    new_d   = '0;
    det_d   = det_mask;
    vcnt_d  = vec_count;
    first_d = first_vec;
    gv_d    = good_v;
    gx_d    = good_x;
    if (clear_faults) begin
      det_d   = '0;
      vcnt_d  = '0;
      first_d = '0;
    end else if (vec_valid) begin
      done_d = 1'b1;
      new_d  = fresh;
      det_d  = det_mask | fresh;
      for (int l = 0; l < NSLOT; l++)
        if (fresh[l]) first_d[l*VIDX_W +: VIDX_W] = vec_count;
      if (vec_count != '1) vcnt_d = vec_count + 1'b1;
      for (int k = 0; k < NPO; k++) begin
        gv_d[k] = po_v[k][LANES-1];
        gx_d[k] = po_x[k][LANES-1];
      end
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      done      <= 1'b0;
      new_det   <= '0;
      det_mask  <= '0;
      vec_count <= '0;
      first_vec <= '0;
      good_v    <= '0;
      good_x    <= '0;
    end else begin
      done    <= done_d;
      new_det <= new_d;
      if (clear_faults || vec_valid) begin
        det_mask  <= det_d;
        vec_count <= vcnt_d;
        first_vec <= first_d;
      end
      if (take) begin
        good_v <= gv_d;
        good_x <= gx_d;
      end
    end
  end

  assign det_count = pop(det_mask & f_en);
  assign sim_count = pop(f_en);

  // R7
  sticky_det_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !clear_faults |=> ((det_mask & $past(det_mask)) == $past(det_mask)));
  // R7
  clear_chk: assert property (@(posedge clk) disable iff (!rst_n)
    clear_faults |=> (det_mask == '0) && (vec_count == '0) && !done);
  // R8
  done_follow_chk: assert property (@(posedge clk) disable iff (!rst_n)
    take |=> done);
  // R8
  new_det_fresh_chk: assert property (@(posedge clk) disable iff (!rst_n)
    1'b1 |=> ((new_det & $past(det_mask)) == '0) && (done || new_det == '0));
  // R13
  vcnt_mono_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !clear_faults |=> vec_count >= $past(vec_count));
  // R10
  cnt_bound_chk: assert property (@(posedge clk) disable iff (!rst_n)
    det_count <= sim_count);

  for (genvar l = 0; l < NSLOT; l++) begin : g_off
    // R11
    off_lane_chk: assert property (@(posedge clk) disable iff (!rst_n)
      !f_en[l] |-> (po_v[0][l] == po_v[0][LANES-1]) && (po_x[0][l] == po_x[0][LANES-1]) &&
                   (po_v[1][l] == po_v[1][LANES-1]) && (po_x[1][l] == po_x[1][LANES-1]));
  end
endmodule

// File: rtl/sa_lane_sim.sv
module sa_lane_sim import fsim_pkg::*; #(
  parameter int LANES  = 8,
  parameter int VIDX_W = 8,
  localparam int NSLOT  = LANES - 1,
  localparam int SLOT_W = $clog2(NSLOT),
  localparam int CNT_W  = $clog2(LANES)
) (
  input  logic                      clk,
  input  logic                      rst_n,
  input  logic                      cfg_we,
  input  logic [SLOT_W-1:0]         cfg_slot,
  input  logic                      cfg_en,
  input  logic [NETW-1:0]           cfg_net,
  input  logic [PIN_W-1:0]          cfg_pin,
  input  logic                      cfg_sv,
  input  logic                      clear_faults,
  input  logic                      vec_valid,
  input  logic [NPI-1:0]            vec_val,
  input  logic [NPI-1:0]            vec_unk,
  output logic                      done,
  output logic [NPO-1:0]            good_v,
  output logic [NPO-1:0]            good_x,
  output logic [NSLOT-1:0]          new_det,
  output logic [NSLOT-1:0]          det_mask,
  output logic [CNT_W-1:0]          det_count,
  output logic [CNT_W-1:0]          sim_count,
  output logic [VIDX_W-1:0]         vec_count,
  output logic [NSLOT*VIDX_W-1:0]   first_vec
);
  logic [1:0]                  rst_sync;
  logic                        rst_n_i;
  logic [NSLOT-1:0][NETW-1:0]  f_net;
  logic [NSLOT-1:0][PIN_W-1:0] f_pin;
  logic [NSLOT-1:0]            f_sv, f_en;
  logic [NPO-1:0][LANES-1:0]   po_v, po_x;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) rst_sync <= 2'b00;
    else        rst_sync <= {rst_sync[0], 1'b1};
  end
  assign rst_n_i = rst_sync[1];

  fsim_fault_table #(.LANES(LANES)) u_tab (
    .clk(clk), .rst_n(rst_n_i), .cfg_we(cfg_we), .cfg_slot(cfg_slot), .cfg_en(cfg_en),
    .cfg_net(cfg_net), .cfg_pin(cfg_pin), .cfg_sv(cfg_sv),
    .f_net(f_net), .f_pin(f_pin), .f_sv(f_sv), .f_en(f_en)
  );

  fsim_eval #(.LANES(LANES)) u_eval (
    .pi_val(vec_val), .pi_unk(vec_unk), .f_net(f_net), .f_pin(f_pin), .f_sv(f_sv),
    .f_en(f_en), .po_v(po_v), .po_x(po_x)
  );

  fsim_detect #(.LANES(LANES), .VIDX_W(VIDX_W)) u_det (
    .clk(clk), .rst_n(rst_n_i), .clear_faults(clear_faults), .vec_valid(vec_valid),
    .po_v(po_v), .po_x(po_x), .f_en(f_en), .done(done), .good_v(good_v), .good_x(good_x),
    .new_det(new_det), .det_mask(det_mask), .det_count(det_count), .sim_count(sim_count),
    .vec_count(vec_count), .first_vec(first_vec)
  );
endmodule

// File: tb/sa_lane_sim_test.sv
`timescale 1ns/1ps
module sa_lane_sim_test;
  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic cfg_we = 1'b0, cfg_en = 1'b0, cfg_sv = 1'b0, clear_faults = 1'b0, vec_valid = 1'b0;
  logic [2:0] cfg_slot = '0;
  logic [3:0] cfg_net = '0;
  logic [1:0] cfg_pin = '0;
  logic [5:0] vec_val = '0, vec_unk = '0;
  logic done;
  logic [1:0] good_v, good_x;
  logic [6:0] new_det, det_mask;
  logic [2:0] det_count, sim_count;
  logic [7:0] vec_count;
  logic [55:0] first_vec;

  int total = 0, bad = 0;
  int m_net [7], m_pin [7];
  logic m_sv [7], m_en [7];
  logic [6:0] m_det = '0, last_fresh = '0;
  logic [7:0] m_first [7];
  int m_vcnt = 0;
  logic c_en; int c_net, c_pin; logic c_sv;

  always #2 clk = ~clk;

  sa_lane_sim uut (.*);

  task automatic chk(input string req, input logic [63:0] act, input logic [63:0] exp);
    total++;
    if (act !== exp) begin
      bad++;
      $display("FAIL %s act=%0h exp=%0h", req, act, exp);
    end
  endtask

  function automatic logic [1:0] tand(input logic [1:0] a, input logic [1:0] b);
    if (a == 2'b00 || b == 2'b00) return 2'b00;
    if (a == 2'b01 && b == 2'b01) return 2'b01;
    return 2'b10;
  endfunction
  function automatic logic [1:0] tor(input logic [1:0] a, input logic [1:0] b);
    if (a == 2'b01 || b == 2'b01) return 2'b01;
    if (a == 2'b00 && b == 2'b00) return 2'b00;
    return 2'b10;
  endfunction
  function automatic logic [1:0] tnot(input logic [1:0] a);
    return (a == 2'b10) ? 2'b10 : {1'b0, ~a[0]};
  endfunction
  function automatic logic [1:0] hk(input logic [1:0] v, input int net, input int pin);
    if (c_en && c_net == net && c_pin == pin) return {1'b0, c_sv};
    return v;
  endfunction

  // returns {po1, po0}, each {x,v}
  function automatic logic [3:0] eval_lane(input logic [5:0] vv, input logic [5:0] vu);
    logic [1:0] n [14];
    for (int i = 0; i < 6; i++) n[i] = hk(vu[i] ? 2'b10 : {1'b0, vv[i]}, i, 0);
    n[6]  = hk(tand(hk(n[0], 6, 1), hk(n[1], 6, 2)), 6, 0);
    n[7]  = hk(tand(hk(n[2], 7, 1), hk(n[3], 7, 2)), 7, 0);
    n[8]  = hk(tor(hk(n[6], 8, 1), hk(n[7], 8, 2)), 8, 0);
    n[9]  = hk(tnot(hk(n[8], 9, 1)), 9, 0);
    n[10] = hk(tor(hk(n[4], 10, 1), hk(n[5], 10, 2)), 10, 0);
    n[11] = hk(tand(hk(n[9], 11, 1), hk(n[10], 11, 2)), 11, 0);
    n[12] = hk(tnot(hk(n[4], 12, 1)), 12, 0);
    n[13] = hk(tor(hk(n[7], 13, 1), hk(n[12], 13, 2)), 13, 0);
    return {n[13], n[11]};
  endfunction

  task automatic cfg(input int slot, input logic en, input int net, input int pin, input logic sv);
    @(negedge clk);
    cfg_we = 1'b1; cfg_slot = 3'(slot); cfg_en = en; cfg_net = 4'(net); cfg_pin = 2'(pin); cfg_sv = sv;
    @(negedge clk);
    cfg_we = 1'b0;
    if (slot < 7) begin
      m_en[slot] = en; m_net[slot] = net; m_pin[slot] = pin; m_sv[slot] = sv;
    end
  endtask

  task automatic apply_vec(input logic [5:0] vv, input logic [5:0] vu);
    logic [3:0] g, f;
    logic [6:0] fresh;
    logic [1:0] exp_gv, exp_gx;
    int ecnt;
    vec_val = vv; vec_unk = vu; vec_valid = 1'b1;
    @(negedge clk);
    vec_valid = 1'b0;
    c_en = 1'b0;
    g = eval_lane(vv, vu);
    fresh = '0;
    for (int l = 0; l < 7; l++) begin
      c_en = m_en[l]; c_net = m_net[l]; c_pin = m_pin[l]; c_sv = m_sv[l];
      f = eval_lane(vv, vu);
      for (int k = 0; k < 2; k++)
        if (m_en[l] && !g[2*k+1] && !f[2*k+1] && (g[2*k] != f[2*k]) && !m_det[l]) fresh[l] = 1'b1;
    end
    for (int l = 0; l < 7; l++) if (fresh[l]) m_first[l] = 8'(m_vcnt);
    m_det = m_det | fresh;
    if (m_vcnt < 255) m_vcnt++;
    last_fresh = fresh;
    exp_gv = {g[2], g[0]}; exp_gx = {g[3], g[1]};
    ecnt = 0;
    for (int l = 0; l < 7; l++) if (m_det[l] && m_en[l]) ecnt++;
    chk("R8 done", done, 1'b1);
    chk("R8/R6 new_det", new_det, fresh);
    chk("R7/R6 det_mask", det_mask, m_det);
    chk("R1/R2/R3 good_v", good_v, exp_gv);
    chk("R1/R2/R3 good_x", good_x, exp_gx);
    chk("R10 det_count", det_count, ecnt);
    chk("R13 vec_count", vec_count, m_vcnt);
    for (int l = 0; l < 7; l++)
      if (fresh[l]) chk("R9 first_vec", first_vec[l*8 +: 8], m_first[l]);
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    total++; bad++;
    $display("FAIL watchdog expired");
    $display("  test done: total=%0d bad=%0d", total, bad);
    $finish;
  end

  initial begin
    int seed;
    logic [5:0] rv, ru;
    seed = $urandom(32'd4242);
    for (int l = 0; l < 7; l++) begin
      m_en[l] = 0; m_net[l] = 0; m_pin[l] = 0; m_sv[l] = 0; m_first[l] = '0;
    end
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    repeat (3) @(negedge clk);
    // R12 reset state
    chk("R12 done", done, 1'b0);
    chk("R12 det_mask", det_mask, 7'd0);
    chk("R12 new_det", new_det, 7'd0);
    chk("R12 vec_count", vec_count, 8'd0);
    chk("R12 sim_count", sim_count, 3'd0);
    chk("R12 det_count", det_count, 3'd0);

    cfg(0, 1, 9, 0, 1);   // NOR output stuck-at-1
    cfg(1, 1, 8, 0, 1);   // OR output stuck-at-1
    cfg(2, 1, 0, 0, 0);   // input p0 stuck-at-0
    cfg(3, 1, 13, 2, 0);  // pin B of n13 stuck-at-0
    cfg(4, 1, 4, 0, 1);   // input p4 stuck-at-1 (stem, two readers)
    cfg(5, 1, 11, 1, 0);  // pin A of n11 stuck-at-0
    cfg(6, 0, 11, 0, 1);  // disabled slot
    cfg(7, 1, 0, 0, 1);   // R4 out-of-range slot, ignored
    chk("R10/R4 sim_count", sim_count, 3'd6);

    // R1 all-zero vector: po0=0, po1=1; R5 stem p4 flips both readers
    apply_vec(6'b000000, 6'b000000);
    chk("R1 good_v zero vector", good_v, 2'b10);
    chk("R5 stem fault lane4", last_fresh[4], 1'b1);
    chk("R5 pin B fault lane3", last_fresh[3], 1'b1);
    // R6 healthy po0 unknown, lane1 known 0: no detection
    apply_vec(6'b010000, 6'b000011);
    chk("R2 good_x unknown", good_x, 2'b01);
    chk("R6 no detect on good X", det_mask[1], 1'b0);
    // R3 AND with known 0 masks X; OR with known 1 masks X
    apply_vec(6'b010000, 6'b100001);
    chk("R3 known through X", good_x, 2'b00);
    chk("R3 po0 value", good_v, 2'b01);
    chk("R5 pin A fault lane5", last_fresh[5], 1'b1);
    // R11 disabled slot never detected
    chk("R11 lane6 off", det_mask[6], 1'b0);

    for (int i = 0; i < 300; i++) begin
      rv = 6'($urandom);
      ru = 6'($urandom) & 6'($urandom) & 6'($urandom);
      apply_vec(rv, ru);
    end
    chk("R13 vec_count saturated", vec_count, 8'd255);

    // R7 clear beats a simultaneous vector
    @(negedge clk);
    clear_faults = 1'b1; vec_valid = 1'b1; vec_val = 6'b000000; vec_unk = '0;
    @(negedge clk);
    clear_faults = 1'b0; vec_valid = 1'b0;
    chk("R7 clear det_mask", det_mask, 7'd0);
    chk("R7 clear vec_count", vec_count, 8'd0);
    chk("R7 clear drops vector", done, 1'b0);
    m_det = '0; m_vcnt = 0;

    // R4 pin code 3 has no effect
    cfg(6, 1, 11, 3, 1);
    chk("R10 sim_count seven", sim_count, 3'd7);
    for (int i = 0; i < 40; i++) apply_vec(6'($urandom), 6'd0);
    chk("R4 pin code 3 inert", det_mask[6], 1'b0);

    $display("  test done: total=%0d bad=%0d", total, bad);
    $finish;
  end
endmodule